// File: doc/BRIEF.md
# Fully Associative Micro Translation Buffer

This block is a ten-slot translation cache placed in front of a larger main translation buffer. On every cycle a request supplies a 32-bit virtual address together with its security state, privilege level and read/write direction. All ten slots are compared against the request at the same time, and the hit/miss result and the physical address come out in that same cycle. The access-permission check and a set of secondary memory attributes, which the line-fill logic uses, are registered and show up one cycle after the lookup.

A slot matches when it is valid, its virtual page number equals the request's page number, and its stored security tag equals the request's security state. It must also either be marked global or hold an address-space identifier equal to the current one, which comes in on an 8-bit input.

When a lookup misses, the surrounding logic fetches a translation from the main buffer and presents it on the refill port. The block writes it into a victim slot. An empty slot is always used first. When every slot is full, the victim comes from either a round-robin pointer or a free-running pseudo-random generator. A flush input empties the whole structure in one cycle.

Top module: `utlb_top`

## Requirements
- R1: While `lk_valid` is high, `lk_hit` or `lk_miss` (exactly one) is asserted in the same cycle. On a hit, `lk_pa` equals the slot's 20-bit physical page number followed by bits [11:0] of `lk_va`. Pages are 4 KB and the virtual page number is `lk_va[31:12]`.
- R2: A slot whose global flag is 0 hits only when its stored identifier equals `cur_asid`.
- R3: A slot whose global flag is 1 hits regardless of `cur_asid`.
- R4: Each slot's security tag is the value of `fill_secure` when it was written. A lookup hits only when `lk_secure` equals that tag.
- R5: `lk_abort` rises in the cycle after a hitting lookup that breaks the slot's permission. It is never high after a miss or after an idle cycle. The permission codes are: 2'b00 no access (always faults), 2'b01 privileged read/write (faults when `lk_user`=1), 2'b10 read-only (faults when `lk_write`=1), 2'b11 full read/write (never faults).
- R6: `lk_attr` carries the hitting slot's 4-bit secondary attributes in the cycle after the lookup. It is zero after a miss.
- R7: A refill goes into the lowest-numbered empty slot whenever one exists.
- R8: A round-robin pointer starts at 0 and advances by one, wrapping from 9 back to 0, on every accepted refill. When no slot is empty, the refill overwrites the slot the pointer selects.
- R9: The pseudo-random victim is used only when `rand_sel` and `rand_en` are both 1. In that case a refill into a full buffer replaces exactly one existing slot. In every other case the round-robin rule applies.
- R10: `flush` invalidates every slot and returns the pointer to 0 on the next clock edge. A refill presented in the same cycle as a flush is discarded.
- R11: After reset every slot is empty, so lookups miss, and `lk_abort` and `lk_attr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cur_asid | input | 8 | Current address-space identifier |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Lookup virtual address |
| lk_secure | input | 1 | Requester is in secure state |
| lk_user | input | 1 | Requester is unprivileged |
| lk_write | input | 1 | Request is a write |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| lk_miss | output | 1 | Lookup missed (same cycle) |
| lk_pa | output | 32 | Translated physical address (same cycle) |
| lk_abort | output | 1 | Permission fault, one cycle after lookup |
| lk_attr | output | 4 | Secondary attributes, one cycle after lookup |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page number |
| fill_asid | input | 8 | Refill address-space identifier |
| fill_global | input | 1 | Refill global flag |
| fill_perm | input | 2 | Refill permission code |
| fill_attr | input | 4 | Refill secondary attributes |
| fill_secure | input | 1 | Security state of the requester causing the refill |
| flush | input | 1 | Invalidate all slots |
| rand_sel | input | 1 | Random replacement requested |
| rand_en | input | 1 | Random replacement permitted |

## Verification
The checker examines properties on every cycle: hit and miss are mutually exclusive during a lookup, an abort or a nonzero attribute only follows a hit, a flush empties the valid set and clears the pointer, the victim index stays below ten, an empty slot is chosen while one exists, and the pointer steps once per accepted refill. The match rules for identifier, global flag and security tag, the permission decode, and the content of the translated address can only be shown by the bench, which loads known translations and looks them up. The same holds for which translation a full-buffer eviction actually removes, the gating of random mode, and a refill being discarded when it coincides with a flush.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
    localparam int ENTRIES = 10;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = 20;
    localparam int ASID_W  = 8;
    localparam int ATTR_W  = 4;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int LFSR_W  = 16;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_PRIV = 2'b01,
        PERM_RO   = 2'b10,
        PERM_RW   = 2'b11
    } perm_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              secure;
        perm_e             perm;
        logic [ATTR_W-1:0] attr;
    } slot_t;

    function automatic logic perm_fault(perm_e p, logic user, logic wr);
        case (p)
            PERM_NONE: return 1'b1;
            PERM_PRIV: return user;
            PERM_RO:   return wr;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/utlb_match.sv
module utlb_match
    import utlb_pkg::*;
(
    input  slot_t              slots [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASID_W-1:0]  asid,
    input  logic               secure,
    output logic [ENTRIES-1:0] hit_vec
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic asid_ok;
        assign asid_ok    = slots[i].glob || (slots[i].asid == asid);
        assign hit_vec[i] = valid[i] && (slots[i].vpn == vpn)
                            && asid_ok && (slots[i].secure == secure);
    end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim
    import utlb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fill_go,
    input  logic               flush,
    input  logic [ENTRIES-1:0] valid,
    input  logic               use_random,
    output logic [IDX_W-1:0]   victim,
    output logic [IDX_W-1:0]   rr_ptr
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  rnd_idx;
    logic              any_free;

    always_ff @(posedge clk) begin
        if (rst)
            lfsr_q <= LFSR_W'(16'hACE1);
        else
            lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_W'(16'hB400) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush)
            rr_ptr <= '0;
        else if (fill_go)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign rnd_idx = IDX_W'(lfsr_q[7:0] % 8'(ENTRIES));

    always_comb begin
        if (any_free)
            victim = free_idx;
        else if (use_random)
            victim = rnd_idx;
        else
            victim = rr_ptr;
    end
endmodule

// File: rtl/utlb_top.sv
module utlb_top
    import utlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cur_asid,
    input  logic              lk_valid,
    input  logic [31:0]       lk_va,
    input  logic              lk_secure,
    input  logic              lk_user,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [31:0]       lk_pa,
    output logic              lk_abort,
    output logic [3:0]        lk_attr,
    input  logic              fill_valid,
    input  logic [19:0]       fill_vpn,
    input  logic [19:0]       fill_ppn,
    input  logic [7:0]        fill_asid,
    input  logic              fill_global,
    input  logic [1:0]        fill_perm,
    input  logic [3:0]        fill_attr,
    input  logic              fill_secure,
    input  logic              flush,
    input  logic              rand_sel,
    input  logic              rand_en
);
    slot_t              slots_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   sel_idx;
    slot_t              sel_slot;
    slot_t              new_slot;
    logic               any_hit;
    logic               fill_go;

    assign fill_go = fill_valid && !flush;

    assign new_slot = '{vpn: fill_vpn, ppn: fill_ppn, asid: fill_asid,
                        glob: fill_global, secure: fill_secure,
                        perm: perm_e'(fill_perm), attr: fill_attr};

    utlb_match u_match (
        .slots   (slots_q),
        .valid   (valid_q),
        .vpn     (lk_va[VA_W-1:OFF_W]),
        .asid    (cur_asid),
        .secure  (lk_secure),
        .hit_vec (hit_vec)
    );

    utlb_victim u_victim (
        .clk        (clk),
        .rst        (rst),
        .fill_go    (fill_go),
        .flush      (flush),
        .valid      (valid_q),
        .use_random (rand_sel && rand_en),
        .victim     (victim_idx),
        .rr_ptr     (rr_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst || flush)
            valid_q <= '0;
        else if (fill_go)
            valid_q[victim_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_go)
            slots_q[victim_idx] <= new_slot;
    end

    always_comb begin
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (hit_vec[i]) sel_idx = IDX_W'(i);
    end

    assign sel_slot = slots_q[sel_idx];
    assign any_hit  = |hit_vec;
    assign lk_hit   = lk_valid && any_hit;
    assign lk_miss  = lk_valid && !any_hit;
    assign lk_pa    = {sel_slot.ppn, lk_va[OFF_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_abort <= 1'b0;
            lk_attr  <= '0;
        end else begin
            lk_abort <= lk_hit && perm_fault(sel_slot.perm, lk_user, lk_write);
            lk_attr  <= lk_hit ? sel_slot.attr : '0;
        end
    end
endmodule

// File: rtl/utlb_checker.sv
module utlb_checker
    import utlb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_abort,
    input logic [3:0]         lk_attr,
    input logic               flush,
    input logic               fill_valid,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [IDX_W-1:0]   victim,
    input logic [IDX_W-1:0]   rr_ptr
);
    p_hit_xor_miss_r1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_hit ^ lk_miss));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));

    p_abort_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |=> !lk_abort);

    p_attr_clear_on_miss_r6: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |=> (lk_attr == '0));

    p_prefer_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !(&valid_vec)) |-> !valid_vec[victim]);

    p_victim_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (victim < IDX_W'(ENTRIES)));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !flush) |=>
            (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1)));

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!fill_valid && !flush) |=> $stable(rr_ptr));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0 && rr_ptr == '0));
endmodule

bind utlb_top utlb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_abort   (lk_abort),
    .lk_attr    (lk_attr),
    .flush      (flush),
    .fill_valid (fill_valid),
    .valid_vec  (valid_q),
    .victim     (victim_idx),
    .rr_ptr     (rr_ptr)
);

// File: tb/tb_utlb_top.sv
module tb_utlb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cur_asid = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_secure = 1'b0, lk_user = 1'b0, lk_write = 1'b0;
    logic        lk_hit, lk_miss, lk_abort;
    logic [31:0] lk_pa;
    logic [3:0]  lk_attr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic [7:0]  fill_asid = '0;
    logic        fill_global = 1'b0;
    logic [1:0]  fill_perm = '0;
    logic [3:0]  fill_attr = '0;
    logic        fill_secure = 1'b0;
    logic        flush = 1'b0, rand_sel = 1'b0, rand_en = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    utlb_top dut (.*);

    typedef struct packed {
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic        sec;
        logic        user;
        logic        wr;
        logic        ehit;
        logic [19:0] eppn;
        logic        eabort;
        logic [3:0]  eattr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{20'h00010, 8'h05, 1'b0, 1'b1, 1'b0, 1'b1, 20'hA0010, 1'b0, 4'h1},
        '{20'h00010, 8'h06, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00000, 1'b0, 4'h0},
        '{20'h00020, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 20'hA0020, 1'b0, 4'h2},
        '{20'h00020, 8'h33, 1'b0, 1'b0, 1'b1, 1'b1, 20'hA0020, 1'b1, 4'h2},
        '{20'h00030, 8'h05, 1'b0, 1'b1, 1'b0, 1'b1, 20'hA0030, 1'b1, 4'h3},
        '{20'h00030, 8'h05, 1'b0, 1'b0, 1'b1, 1'b1, 20'hA0030, 1'b0, 4'h3},
        '{20'h00030, 8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 4'h0},
        '{20'h00040, 8'h05, 1'b0, 1'b0, 1'b0, 1'b1, 20'hA0040, 1'b1, 4'h4},
        '{20'h00050, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 4'h0},
        '{20'h00050, 8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 20'hA0050, 1'b0, 4'h5},
        '{20'h00010, 8'h05, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 1'b0, 4'h0},
        '{20'h00060, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 4'h0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [7:0] asid, input logic g, input logic [1:0] perm,
                        input logic [3:0] attr, input logic sec, input logic fl);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = asid;
        fill_global = g; fill_perm = perm; fill_attr = attr; fill_secure = sec;
        flush = fl;
        @(negedge clk);
        fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    // Full lookup with same-cycle and next-cycle checks.
    task automatic lookup(input vec_t v, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = {v.vpn, 12'hABC}; cur_asid = v.asid;
        lk_secure = v.sec; lk_user = v.user; lk_write = v.wr;
        #1;
        check(lk_hit == v.ehit && lk_miss == !v.ehit, req, "hit/miss",
              {30'd0, lk_hit, lk_miss}, {30'd0, v.ehit, !v.ehit});
        if (v.ehit)
            check(lk_pa == {v.eppn, 12'hABC}, req, "pa", lk_pa, {v.eppn, 12'hABC});
        @(negedge clk);
        lk_valid = 1'b0;
        check(lk_abort == v.eabort, req, "abort", {31'd0, lk_abort}, {31'd0, v.eabort});
        check(lk_attr == v.eattr, req, "attr", {28'd0, lk_attr}, {28'd0, v.eattr});
    endtask

    // Hit probe with global-style lookup, no checks.
    task automatic probe(input logic [19:0] vpn, output logic hit);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = {vpn, 12'h000}; cur_asid = 8'h00;
        lk_secure = 1'b0; lk_user = 1'b0; lk_write = 1'b0;
        #1 hit = lk_hit;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic h;
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: empty after reset
        lookup('{20'h00010, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0, 1'b0, 4'h0}, "R11");

        // Load known translations (slots 0..4)
        fill(20'h00010, 20'hA0010, 8'h05, 1'b0, 2'b11, 4'h1, 1'b0, 1'b0);
        fill(20'h00020, 20'hA0020, 8'h77, 1'b1, 2'b10, 4'h2, 1'b0, 1'b0);
        fill(20'h00030, 20'hA0030, 8'h05, 1'b0, 2'b01, 4'h3, 1'b0, 1'b0);
        fill(20'h00040, 20'hA0040, 8'h77, 1'b1, 2'b00, 4'h4, 1'b0, 1'b0);
        fill(20'h00050, 20'hA0050, 8'h77, 1'b1, 2'b11, 4'h5, 1'b1, 1'b0);

        // Vector table: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++)
            lookup(VEC[i], "R1-table/R2/R3/R4/R5/R6");

        // R10: flush empties everything
        do_flush();
        lookup('{20'h00010, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0, 1'b0, 4'h0}, "R10");
        lookup('{20'h00020, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0, 1'b0, 4'h0}, "R10");

        // R7/R8: fill ten, eleventh evicts first slot (pointer back at 0)
        for (int i = 0; i < 10; i++)
            fill(20'h00300 + 20'(i), 20'hB0300 + 20'(i), 8'h00, 1'b1, 2'b11, 4'h0, 1'b0, 1'b0);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            probe(20'h00300 + 20'(i), h);
            cnt += int'(h);
        end
        check(cnt == 10, "R7", "resident count", 32'(cnt), 32'd10);
        // R9 gating: rand_sel alone keeps round-robin
        rand_sel = 1'b1; rand_en = 1'b0;
        fill(20'h00400, 20'hB0400, 8'h00, 1'b1, 2'b11, 4'h0, 1'b0, 1'b0);
        probe(20'h00300, h);
        check(h == 1'b0, "R8", "slot0 evicted", {31'd0, h}, 32'd0);
        probe(20'h00301, h);
        check(h == 1'b1, "R9", "slot1 kept", {31'd0, h}, 32'd1);
        probe(20'h00400, h);
        check(h == 1'b1, "R8", "new entry hit", {31'd0, h}, 32'd1);
        fill(20'h00401, 20'hB0401, 8'h00, 1'b1, 2'b11, 4'h0, 1'b0, 1'b0);
        probe(20'h00301, h);
        check(h == 1'b0, "R8", "slot1 evicted next", {31'd0, h}, 32'd0);
        probe(20'h00302, h);
        check(h == 1'b1, "R8", "slot2 kept", {31'd0, h}, 32'd1);

        // R10: refill together with flush is discarded
        fill(20'h00500, 20'hB0500, 8'h00, 1'b1, 2'b11, 4'h0, 1'b0, 1'b1);
        probe(20'h00500, h);
        check(h == 1'b0, "R10", "fill during flush", {31'd0, h}, 32'd0);
        probe(20'h00400, h);
        check(h == 1'b0, "R10", "flushed entry", {31'd0, h}, 32'd0);

        // R9: random eviction replaces exactly one resident entry
        rand_sel = 1'b1; rand_en = 1'b1;
        for (int i = 0; i < 10; i++)
            fill(20'h00100 + 20'(i), 20'hC0100 + 20'(i), 8'h00, 1'b1, 2'b11, 4'h0, 1'b0, 1'b0);
        fill(20'h00200, 20'hC0200, 8'h00, 1'b1, 2'b11, 4'h0, 1'b0, 1'b0);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            probe(20'h00100 + 20'(i), h);
            cnt += int'(h);
        end
        check(cnt == 9, "R9", "survivors after random eviction", 32'(cnt), 32'd9);
        probe(20'h00200, h);
        check(h == 1'b1, "R9", "random-filled entry hit", {31'd0, h}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule